// File: doc/BRIEF.md
# Three-Bit Reversible Gray Code Counter

This block is a fully synchronous three-bit counter whose state walks a reflected Gray code ring. On each clock edge with enable high, the state moves one position forward or backward around the ring. A direction input picks the way. With enable low, the state stays where it is. All three state bits sit in one register bank clocked by the same edge, so no output bit ripples from another.

Because neighbouring codes differ in a single bit, the state word can be sampled by logic that has no fixed timing relation to the counter without ever reading a mixed code.

A registered wrap flag marks a step out of the last code of the ring in the current direction. The flag is high for the one cycle that follows such a step.

Top module: `gray_step_counter`

## Requirements
- R1: A synchronous active-high `rst` forces `state` to 3'b000 and `wrap_flag` to 0 on the next edge, whatever the values of `en` and `up`.
- R2: With `en`=1 and `up`=1, `state` advances one code per edge through the ring 000, 001, 011, 010, 110, 111, 101, 100 and then returns to 000.
- R3: With `en`=1 and `up`=0, `state` walks the same ring backwards, so 000 steps to 100 and 100 steps to 101.
- R4: With `en`=0, `state` keeps its value across the edge for either value of `up`.
- R5: Every enabled step changes exactly one bit of `state`, in both directions.
- R6: After each edge without reset, `wrap_flag` is 1 exactly when, before that edge, `en` was 1 and either `up`=1 with `state`=100 or `up`=0 with `state`=000. Otherwise `wrap_flag` is 0.
- R7: Changing `up` between two enabled edges takes effect on the very next edge, so an up step followed by a down step returns to the starting code.
- R8: The ring holds eight distinct codes: eight enabled steps in one direction return the state to its starting code, and no code repeats before that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable; low holds the state |
| up | input | 1 | Direction: 1 forward around the ring, 0 backward |
| state | output | 3 | Current Gray code |
| wrap_flag | output | 1 | Registered one-cycle mark of a step out of the last code in the current direction |

## Verification
Two functions can fall in the same cycle. Reset can arrive while an enabled step would leave the terminal code and raise the wrap flag. A direction reversal can also land exactly on a terminal code. The bench provokes the first case by raising reset with enable high while the state is 100 and counting up; it expects 000 with the flag clear on the next edge. It provokes the second by flipping direction at 000 and at 100, and judges every edge against a behavioural ring-index model.

// File: rtl/gray_step_pkg.sv
package gray_step_pkg;
  localparam int unsigned GW = 3;
  localparam int unsigned RING = 1 << GW;
  typedef logic [GW-1:0] code_t;

  function automatic code_t to_bin(input code_t g);
    code_t b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic code_t to_gray(input code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray_step(input code_t g, input logic fwd);
    code_t b;
    b = to_bin(g);
    b = fwd ? b + code_t'(1) : b - code_t'(1);
    return to_gray(b);
  endfunction

  function automatic code_t last_code(input logic fwd);
    return fwd ? to_gray({GW{1'b1}}) : '0;
  endfunction
endpackage

// File: rtl/gray_next_logic.sv
module gray_next_logic
  import gray_step_pkg::*;
(
  input  code_t cur,
  input  logic  fwd,
  output code_t nxt,
  output logic  at_last
);
  assign nxt     = gray_step(cur, fwd);
  assign at_last = (cur == last_code(fwd));
endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg
  import gray_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t nxt,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q)); // R4
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst) en |=> ($countones(q ^ $past(q)) == 1)); // R5
endmodule

// File: rtl/gray_wrap_flag.sv
module gray_wrap_flag (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic at_last,
  output logic flag
);
  logic wrap_evt;
  assign wrap_evt = en & at_last;

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= wrap_evt;
  end

  AST_FLAG_RESET_LOW: assert property (@(posedge clk) rst |=> !flag); // R1
endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter
  import gray_step_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          up,
  output logic [GW-1:0] state,
  output logic          wrap_flag
);
  code_t cur_q;
  code_t nxt_c;
  logic  at_last_c;

  gray_next_logic u_next (
    .cur     (cur_q),
    .fwd     (up),
    .nxt     (nxt_c),
    .at_last (at_last_c)
  );

  gray_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .nxt (nxt_c),
    .q   (cur_q)
  );

  gray_wrap_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .at_last (at_last_c),
    .flag    (wrap_flag)
  );

  assign state = cur_q;

  AST_FLAG_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap_flag |-> ($past(up) ? (state == 3'b000) : (state == 3'b100))); // R6
  AST_TURN_BACK: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst) && (up != $past(up))) |=> (state == $past(state, 2))); // R7
endmodule

// File: tb/gray_step_counter_bench.sv
module gray_step_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       up = 1'b1;
  logic [2:0] state;
  logic       wrap_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] ring [8] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111, 3'b101, 3'b100};
  int         pos = 0;
  logic       flag_m = 1'b0;
  logic [2:0] prev_state;

  gray_step_counter u_gray_step_counter (
    .clk (clk), .rst (rst), .en (en), .up (up),
    .state (state), .wrap_flag (wrap_flag)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic u, input string tag);
    @(negedge clk);
    rst = r; en = e; up = u;
    prev_state = state;
    @(posedge clk);
    if (r) begin
      pos = 0; flag_m = 1'b0;
    end else begin
      flag_m = e && (u ? (pos == 7) : (pos == 0));
      if (e) pos = u ? (pos + 1) % 8 : (pos + 7) % 8;
    end
    #1;
    check(tag, {1'b0, state}, {1'b0, ring[pos]});
    check({tag, " flag R6"}, {3'b0, wrap_flag}, {3'b0, flag_m});
    if (!r && e) check("R5 one bit per step", 4'($countones(state ^ prev_state)), 4'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] start;
    logic [7:0] seen;
    for (int i = 0; i < 3; i++) step(1, 1, 1, "R1 reset");
    for (int i = 0; i < 10; i++) step(0, 1, 1, "R2 up ring");
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R4 hold up");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R4 hold down");
    for (int i = 0; i < 11; i++) step(0, 1, 0, "R3 down ring");
    step(0, 1, 1, "R7 turn");
    step(0, 1, 0, "R7 turn back");
    step(0, 1, 1, "R7 turn again");
    while (pos != 7) step(0, 1, 1, "R2 to last");
    step(0, 1, 0, "R7 reverse at 100");
    step(0, 1, 1, "R7 forward to 100");
    step(1, 1, 1, "R1 reset beats wrap");
    check("R1 flag after reset", {3'b0, wrap_flag}, 4'd0);
    step(0, 1, 0, "R3 000 to 100");
    for (int d = 0; d < 2; d++) begin
      start = state;
      seen = '0;
      for (int i = 0; i < 8; i++) begin
        check("R8 no repeat", {3'b0, seen[state]}, 4'd0);
        seen[state] = 1'b1;
        step(0, 1, d == 0, "R8 ring step");
      end
      check("R8 back to start", {1'b0, state}, {1'b0, start});
      check("R8 all codes", {3'b0, &seen}, 4'd1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule